// File: doc/BRIEF.md
# Vector High-Narrowing Add/Subtract Unit

The unit takes two 128-bit source vectors made of double-width lanes. For each lane pair it forms the sum or the difference at full double width, adds an optional rounding bias of half a result LSB, and keeps only the upper half as a narrow result lane. The narrow lanes fill 64 bits. They are written either into the lower half of the destination, with the upper half cleared, or into the upper half, with the lower half kept from the current destination value.

The controls come from a 32-bit instruction word that the unit decodes itself: the element size, add or subtract, rounding, and which half of the destination to write. An element size that would need 128-bit source lanes, or an opcode outside the two supported ones, raises an illegal flag and leaves the destination unchanged. The result is registered on the clock edge where the valid strobe is high. Every source lane is read before that edge, so the destination may also be one of the sources.

Top module: `hn_narrow_unit`

## Requirements
- R1: Instruction decode: bit 29 set selects rounding, bit 30 set selects the upper destination half, bits [23:22] give the element size code, and bits [15:12] give the operation, where 4'b0100 is add and 4'b0110 is subtract. Any other value in [15:12] is illegal.
- R2: Element size code 3 is illegal. On an illegal strobe, illegal_o goes to 1 and dst_o takes the value of dst_i. On a legal strobe, illegal_o goes to 0.
- R3: Size code 0 gives eight 8-bit results from 16-bit source lanes. Code 1 gives four 16-bit results from 32-bit lanes. Code 2 gives two 32-bit results from 64-bit lanes. Source lane i occupies bits [i*2E +: 2E] of each source.
- R4: Add: each result lane is the upper E bits of (a + b) mod 2^(2E). A carry out of the wide lane is dropped.
- R5: Subtract: each result lane is the upper E bits of (a - b) mod 2^(2E), where a comes from src_a_i. A borrow wraps.
- R6: Rounding adds 2^(E-1) to the wide sum or difference before the upper half is taken. The addition wraps modulo 2^(2E).
- R7: With the top select clear, result lane i lands in destination bits [i*E +: E] and dst_o[127:64] is zero.
- R8: With the top select set, result lane i lands in destination lane i + 64/E, so the results fill dst_o[127:64]. dst_o[63:0] equals dst_i[63:0].
- R9: dst_o, illegal_o and valid_o update on the clock edge that samples valid_i high, and valid_o is the registered valid_i. While valid_i is low, dst_o and illegal_o hold their values.
- R10: During reset, dst_o, illegal_o and valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| insn_i | input | 32 | Instruction word with the operation fields |
| src_a_i | input | 128 | First source vector (minuend) |
| src_b_i | input | 128 | Second source vector |
| dst_i | input | 128 | Current destination value |
| dst_o | output | 128 | Registered new destination value |
| illegal_o | output | 1 | Registered illegal-encoding flag |
| valid_o | output | 1 | Registered strobe for dst_o |

## Verification
The cases that are hardest to reach from the ports are the ones where the rounding bias carries all the way into the kept half, or wraps the whole wide lane. Purely random operands almost never land there. To hit these, the stimulus builds lanes whose lower half is at or just below the half-LSB threshold, and lanes of all ones and all zeros, for every size code and both destination halves. Random operands and opcodes, including illegal ones, are mixed in next to this directed set. The model is compared on every cycle, idle cycles included.

// File: rtl/hn_pkg.sv
package hn_pkg;
  localparam int VLEN     = 128;
  localparam int HALF     = VLEN / 2;
  localparam int NSIZES   = 3;
  localparam int INSN_W   = 32;
  localparam logic [3:0] OP_ADD = 4'b0100;
  localparam logic [3:0] OP_SUB = 4'b0110;

  typedef struct packed {
    logic [1:0] size;
    logic       sub;
    logic       rnd;
    logic       top;
    logic       illegal;
  } hn_ctrl_t;
endpackage

// File: rtl/hn_decode.sv
module hn_decode
  import hn_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output hn_ctrl_t          ctrl_o
);
  logic [3:0] op;
  logic       op_ok;

  always_comb begin
    op             = insn_i[15:12];
    op_ok          = (op == OP_ADD) || (op == OP_SUB);
    ctrl_o.size    = insn_i[23:22];
    ctrl_o.sub     = (op == OP_SUB);
    ctrl_o.rnd     = insn_i[29];
    ctrl_o.top     = insn_i[30];
    ctrl_o.illegal = !op_ok || (insn_i[23:22] == 2'd3);
  end
endmodule

// File: rtl/hn_lane.sv
module hn_lane #(
  parameter int EW = 8
) (
  input  logic [2*EW-1:0] a_i,
  input  logic [2*EW-1:0] b_i,
  input  logic            sub_i,
  input  logic            rnd_i,
  output logic [EW-1:0]   hi_o
);
  localparam int WW = 2 * EW;
  localparam logic [WW-1:0] BIAS = WW'(1) << (EW - 1);

  logic [WW-1:0] wide;

  always_comb begin
    wide = sub_i ? (a_i - b_i) : (a_i + b_i);
    if (rnd_i) wide = wide + BIAS;
    hi_o = wide[WW-1:EW];
  end
endmodule

// File: rtl/hn_bank.sv
module hn_bank #(
  parameter int EW   = 8,
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0]   a_i,
  input  logic [VLEN-1:0]   b_i,
  input  logic              sub_i,
  input  logic              rnd_i,
  output logic [VLEN/2-1:0] narrow_o
);
  localparam int WW = 2 * EW;
  localparam int NL = VLEN / WW;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    hn_lane #(.EW(EW)) u_lane (
      .a_i   (a_i[i*WW +: WW]),
      .b_i   (b_i[i*WW +: WW]),
      .sub_i (sub_i),
      .rnd_i (rnd_i),
      .hi_o  (narrow_o[i*EW +: EW])
    );
  end
endmodule

// File: rtl/hn_pack.sv
module hn_pack #(
  parameter int VLEN = 128
) (
  input  logic [VLEN/2-1:0] narrow_i,
  input  logic [VLEN-1:0]   dst_i,
  input  logic              top_i,
  output logic [VLEN-1:0]   dst_o
);
  localparam int H = VLEN / 2;

  always_comb begin
    if (top_i) dst_o = {narrow_i, dst_i[H-1:0]};
    else       dst_o = {{H{1'b0}}, narrow_i};
  end
endmodule

// File: rtl/hn_narrow_unit.sv
module hn_narrow_unit
  import hn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [VLEN-1:0]   src_a_i,
  input  logic [VLEN-1:0]   src_b_i,
  input  logic [VLEN-1:0]   dst_i,
  output logic [VLEN-1:0]   dst_o,
  output logic              illegal_o,
  output logic              valid_o
);
  hn_ctrl_t        ctrl;
  logic [HALF-1:0] narrow_all [NSIZES];
  logic [HALF-1:0] narrow_sel;
  logic [VLEN-1:0] packed_res;
  logic [VLEN-1:0] dst_d, dst_q;
  logic            ill_d, ill_q;
  logic            vld_q;

  hn_decode u_dec (.insn_i(insn_i), .ctrl_o(ctrl));

  for (genvar g = 0; g < NSIZES; g++) begin : g_bank
    hn_bank #(.EW(8 << g), .VLEN(VLEN)) u_bank (
      .a_i      (src_a_i),
      .b_i      (src_b_i),
      .sub_i    (ctrl.sub),
      .rnd_i    (ctrl.rnd),
      .narrow_o (narrow_all[g])
    );
  end

  always_comb begin
    case (ctrl.size)
      2'd1:    narrow_sel = narrow_all[1];
      2'd2:    narrow_sel = narrow_all[2];
      default: narrow_sel = narrow_all[0];
    endcase
  end

  hn_pack #(.VLEN(VLEN)) u_pack (
    .narrow_i (narrow_sel),
    .dst_i    (dst_i),
    .top_i    (ctrl.top),
    .dst_o    (packed_res)
  );

  // next state
  always_comb begin
    dst_d = dst_q;
    ill_d = ill_q;
    if (valid_i) begin
      ill_d = ctrl.illegal;
      dst_d = ctrl.illegal ? dst_i : packed_res;
    end
  end

  // state registers; reset deassertion is synchronised upstream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      ill_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        dst_q <= dst_d;
        ill_q <= ill_d;
      end
    end
  end

  assign dst_o     = dst_q;
  assign illegal_o = ill_q;
  assign valid_o   = vld_q;
endmodule

// File: rtl/hn_narrow_chk.sv
module hn_narrow_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic [31:0]  insn_i,
  input logic [127:0] src_a_i,
  input logic [127:0] src_b_i,
  input logic [127:0] dst_i,
  input logic [127:0] dst_o,
  input logic         illegal_o,
  input logic         valid_o
);
  logic bad_enc;
  assign bad_enc = (insn_i[23:22] == 2'd3) ||
                   !((insn_i[15:12] == 4'b0100) || (insn_i[15:12] == 4'b0110));

  p_illegal_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && bad_enc) |=> (illegal_o && dst_o == $past(dst_i)));

  p_legal_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !bad_enc) |=> !illegal_o);

  p_bottom_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !bad_enc && !insn_i[30]) |=> (dst_o[127:64] == 64'd0));

  p_top_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !bad_enc && insn_i[30]) |=> (dst_o[63:0] == $past(dst_i[63:0])));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(dst_o) && $stable(illegal_o)));

  p_valid_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);

  p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);

  always_comb begin
    if (!rst_n) begin
      p_reset_zero_r10: assert (dst_o == 128'd0 && !illegal_o && !valid_o);
    end
  end
endmodule

bind hn_narrow_unit hn_narrow_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .dst_i     (dst_i),
  .dst_o     (dst_o),
  .illegal_o (illegal_o),
  .valid_o   (valid_o)
);

// File: tb/hn_narrow_unit_bench.sv
module hn_narrow_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  insn_i = '0;
  logic [127:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [127:0] dst_o;
  logic         illegal_o, valid_o;

  int tests = 0;
  int fails = 0;

  logic [127:0] exp_dst = '0;
  logic         exp_ill = 1'b0;
  logic         exp_vld = 1'b0;

  always #4 clk = ~clk;

  hn_narrow_unit u_hn_narrow_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .dst_o(dst_o), .illegal_o(illegal_o), .valid_o(valid_o)
  );

  function automatic logic [31:0] mk(bit q, bit u, logic [1:0] sz, logic [3:0] op);
    return {1'b0, q, u, 5'b01110, sz, 1'b1, 5'd3, op, 2'b00, 5'd1, 5'd2};
  endfunction

  function automatic void model(input logic [127:0] a, b, d, input logic [31:0] ins,
                                output bit ill, output logic [127:0] r);
    int sz, e, n, base;
    logic [127:0] m2, wa, wb, w, h;
    sz  = int'(ins[23:22]);
    ill = (sz == 3) || !(ins[15:12] == 4'b0100 || ins[15:12] == 4'b0110);
    if (ill) begin r = d; return; end
    e    = 8 << sz;
    n    = 8 >> sz;
    m2   = (128'd1 << (2 * e)) - 128'd1;
    r    = ins[30] ? {64'd0, d[63:0]} : 128'd0;
    base = ins[30] ? n : 0;
    for (int i = 0; i < n; i++) begin
      wa = (a >> (i * 2 * e)) & m2;
      wb = (b >> (i * 2 * e)) & m2;
      w  = (ins[15:12] == 4'b0110) ? wa - wb : wa + wb;
      if (ins[29]) w = w + (128'd1 << (e - 1));
      w  = w & m2;
      h  = w >> e;
      r  = r | (h << ((i + base) * e));
    end
  endfunction

  task automatic compare(string tag);
    tests++;
    if (dst_o !== exp_dst || illegal_o !== exp_ill || valid_o !== exp_vld) begin
      fails++;
      $display("FAIL %s: dst=%h ill=%b vld=%b expected dst=%h ill=%b vld=%b",
               tag, dst_o, illegal_o, valid_o, exp_dst, exp_ill, exp_vld);
    end
  endtask

  // one clock: drive at negedge, model the edge, sample after it
  task automatic step(bit v, logic [31:0] ins, logic [127:0] a, b, d, string tag);
    bit ill;
    logic [127:0] r;
    @(negedge clk);
    valid_i = v; insn_i = ins; src_a_i = a; src_b_i = b; dst_i = d;
    model(a, b, d, ins, ill, r);
    @(posedge clk);
    exp_vld = v;
    if (v) begin exp_dst = r; exp_ill = ill; end
    #2;
    compare(tag);
  endtask

  initial begin : watchdog
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] ra, rb, rd;
    #3;
    compare("R10 reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    compare("R10 after release");

    // R4 add with wrap of the wide lane, all sizes, bottom half
    step(1, mk(0,0,2'd0,4'b0100), {8{16'hFFFF}}, {8{16'h0001}}, {128{1'b1}}, "R4 R7 wrap b");
    step(1, mk(0,0,2'd0,4'b0100), {8{16'h1280}}, {8{16'h0180}}, '0, "R3 R4 size0");
    step(1, mk(0,0,2'd1,4'b0100), {4{32'h1234_8000}}, {4{32'h0001_8000}}, '0, "R3 R4 size1");
    step(1, mk(0,0,2'd2,4'b0100), {2{64'h89AB_CDEF_FFFF_FFFF}}, {2{64'h1}}, '0, "R3 R4 size2");
    // R5 subtract with borrow
    step(1, mk(0,0,2'd0,4'b0110), {8{16'h0000}}, {8{16'h0001}}, '0, "R5 borrow");
    step(1, mk(0,0,2'd1,4'b0110), {4{32'h5000_0000}}, {4{32'h1000_0001}}, '0, "R5 size1");
    // R6 rounding at threshold and wrap
    step(1, mk(0,1,2'd0,4'b0100), {8{16'h007F}}, {8{16'h0001}}, '0, "R6 carry in");
    step(1, mk(0,1,2'd0,4'b0100), {8{16'h007E}}, {8{16'h0001}}, '0, "R6 below");
    step(1, mk(0,1,2'd1,4'b0100), {4{32'hFFFF_8000}}, {4{32'h0}}, '0, "R6 wrap");
    step(1, mk(0,1,2'd2,4'b0110), {2{64'h0}}, {2{64'h1}}, '0, "R5 R6 sub rnd");
    // R8 top half, lower kept
    step(1, mk(1,0,2'd0,4'b0100), {8{16'hAB00}}, {8{16'h0100}}, {4{32'hDEAD_BEEF}}, "R8 top s0");
    step(1, mk(1,1,2'd2,4'b0110), {2{64'h8000_0000_8000_0000}}, {2{64'h1}}, {4{32'h1357_9BDF}}, "R8 top s2");
    // R9 idle holds
    step(0, mk(0,0,2'd0,4'b0100), {8{16'h1111}}, '0, '0, "R9 idle");
    step(0, mk(0,0,2'd0,4'b1111), '0, '0, '1, "R9 idle2");
    // R2 illegal size and R1 illegal opcode
    step(1, mk(0,0,2'd3,4'b0100), {8{16'h2222}}, '0, {4{32'hCAFE_F00D}}, "R2 size3");
    step(1, mk(1,1,2'd0,4'b0101), '1, '1, {4{32'h0BAD_F00D}}, "R1 bad op");
    step(1, mk(0,0,2'd1,4'b0100), {4{32'h0003_0000}}, {4{32'h0004_0000}}, '0, "R2 legal clears");
    // R1 lane distinctness
    step(1, mk(0,0,2'd0,4'b0100),
         128'h0F00_0E00_0D00_0C00_0B00_0A00_0900_0800, '0, '0, "R1 R7 lane order");
    step(1, mk(1,0,2'd1,4'b0110),
         128'h0004_0000_0003_0000_0002_0000_0001_0000, '0, {4{32'h7777_7777}}, "R1 R8 lane order");

    for (int k = 0; k < 400; k++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      rd = {$urandom, $urandom, $urandom, $urandom};
      if (k % 5 == 0) rb = ~ra;
      step(($urandom % 4) != 0,
           mk($urandom % 2, $urandom % 2, 2'($urandom % 4),
              ($urandom % 8 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'b0110 : 4'b0100)),
           ra, rb, rd, "R1 R3 R4 R5 R6 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule